// File: doc/BRIEF.md
# Masked Device Interrupt Router

This block gathers 64 level-sensitive device interrupt inputs into a raw request register. It then fans them out to up to four processors. Each processor has its own 64-bit enable mask. The masked view of the requests is split into two classes:

- The six highest source positions form the error class.
- The 56 lowest positions form the device class.

Each class drives its own interrupt line into every processor. The two positions between the classes reach neither line.

Software reaches the block through a small register port. The port has a 6-bit register index, a write strobe and 64-bit write data. Read data is returned combinationally for whatever index is presented. The per-processor mask registers are the only writable state. The raw request register and the per-processor masked request registers can be read back. The interrupt lines are registered. Prioritising or encoding individual sources is not part of this block, and neither is acknowledge.

Top module: `irq_router`

## Requirements
- R1: On every clock edge outside reset, the raw request register takes the current level of `dev_irq_i`. It reads back at register index 0x1C.
- R2: The masked request of processor c is the raw request ANDed with mask c. It reads back at index 0x0A for c=0, 0x0B for c=1, 0x1A for c=2 and 0x1B for c=3. It reflects a new mask value in the cycle right after the write edge.
- R3: `err_irq_o[c]` is high when any of bits 63:58 of the masked request of processor c is set.
- R4: `dev_irq_o[c]` is high when any of bits 55:0 of the masked request of processor c is set. Bits 57 and 56 affect neither line.
- R5: A write with `reg_wr_i` high loads the full 64-bit `reg_wdata_i` into a mask register. Index 0x08 selects mask 0, 0x09 mask 1, 0x18 mask 2 and 0x19 mask 3. Each mask reads back at its own index.
- R6: A write to any other index leaves every mask unchanged. This includes the masked request indices and the raw index.
- R7: While `rst` is high, all masks, the raw request register and all interrupt lines are zero.
- R8: The lines are registered. An input or mask change becomes visible on the lines at the clock edge after the one that captured it. For an input, that is the first edge after the change. For a mask, it is the edge after the write edge.
- R9: A read of any index other than the mask, masked request and raw indices returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq_i | input | 64 | Level-sensitive device interrupt inputs |
| reg_idx_i | input | 6 | Register index for reads and writes |
| reg_wr_i | input | 1 | Write strobe, one write per cycle |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for `reg_idx_i`, combinational |
| err_irq_o | output | NUM_CPU | Per-processor error-class interrupt line |
| dev_irq_o | output | NUM_CPU | Per-processor device-class interrupt line |

## Verification
The main pattern is a walking single-source sweep across all 64 positions, run with four deliberately different masks:

- all ones;
- error class only;
- the two dead positions only;
- alternating bits.

Together these show which positions belong to which line, that the dead positions stay silent, and that each processor applies its own mask. Dense patterns then confirm that the per-line OR fires on any member. Targeted sequences separate the one-cycle line latency from the immediate masked readback. Writes to read-only and unmapped indices are shown to leave the masks intact.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int SRC_W     = 64;
    localparam int CPU_MAX   = 4;
    localparam int REG_IDX_W = 6;
    localparam int CPU_SEL_W = $clog2(CPU_MAX);
    localparam int ERR_LO    = 58;
    localparam int DEV_HI    = 55;

    localparam logic [REG_IDX_W-1:0] RAW_IDX = 6'h1C;

    typedef logic [SRC_W-1:0] src_vec_t;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_MASK   = 2'd1,
        RK_MASKED = 2'd2,
        RK_RAW    = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [CPU_SEL_W-1:0]   cpu;
    } reg_sel_t;

    typedef struct packed {
        logic err;
        logic dev;
    } cpu_lines_t;

    // The processor number is split over index bit 4 (high) and bit 0 (low).
    function automatic logic [REG_IDX_W-1:0] mask_index(input logic [1:0] c);
        return {1'b0, c[1], 3'b100, c[0]};
    endfunction

    function automatic logic [REG_IDX_W-1:0] masked_index(input logic [1:0] c);
        return {1'b0, c[1], 3'b101, c[0]};
    endfunction

    function automatic reg_sel_t decode_index(input logic [REG_IDX_W-1:0] idx);
        reg_sel_t s;
        s.cpu = {idx[4], idx[0]};
        if (idx == RAW_IDX)
            s.kind = RK_RAW;
        else if (!idx[5] && idx[3:1] == 3'b100)
            s.kind = RK_MASK;
        else if (!idx[5] && idx[3:1] == 3'b101)
            s.kind = RK_MASKED;
        else
            s.kind = RK_NONE;
        return s;
    endfunction

    function automatic logic err_any(input src_vec_t v);
        return |v[SRC_W-1:ERR_LO];
    endfunction

    function automatic logic dev_any(input src_vec_t v);
        return |v[DEV_HI:0];
    endfunction

endpackage

// File: rtl/irq_raw_sampler.sv
module irq_raw_sampler
    import irq_router_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t dev_i,
    output src_vec_t raw_o
);
    src_vec_t raw_q;

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= dev_i;
    end

    assign raw_o = raw_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  reg_sel_t                 sel_i,
    input  src_vec_t                 wdata_i,
    output logic [NUM_CPU*SRC_W-1:0] mask_o
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
        src_vec_t mask_q;
        logic     hit;

        assign hit = wr_i && (sel_i.kind == RK_MASK) && (sel_i.cpu == CPU_SEL_W'(c));

        always_ff @(posedge clk) begin
            if (rst)      mask_q <= '0;
            else if (hit) mask_q <= wdata_i;
        end

        assign mask_o[c*SRC_W +: SRC_W] = mask_q;
    end
endmodule

// File: rtl/irq_cpu_lines.sv
module irq_cpu_lines
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  src_vec_t                 dev_i,
    input  logic [NUM_CPU*SRC_W-1:0] mask_i,
    output logic [NUM_CPU-1:0]       err_o,
    output logic [NUM_CPU-1:0]       dev_o
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        src_vec_t   gated;
        cpu_lines_t nxt;
        cpu_lines_t lines_q;

        // Lines are computed from the live inputs so that they land on the
        // same edge that loads the raw request register.
        assign gated   = dev_i & mask_i[c*SRC_W +: SRC_W];
        assign nxt.err = err_any(gated);
        assign nxt.dev = dev_any(gated);

        always_ff @(posedge clk) begin
            if (rst) lines_q <= '0;
            else     lines_q <= nxt;
        end

        assign err_o[c] = lines_q.err;
        assign dev_o[c] = lines_q.dev;
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  reg_sel_t                 sel_i,
    input  src_vec_t                 raw_i,
    input  logic [NUM_CPU*SRC_W-1:0] mask_i,
    output src_vec_t                 rdata_o
);
    src_vec_t mask_arr [NUM_CPU];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_unpack
        assign mask_arr[c] = mask_i[c*SRC_W +: SRC_W];
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel_i.kind)
            RK_RAW: rdata_o = raw_i;
            RK_MASK: begin
                for (int c = 0; c < NUM_CPU; c++)
                    if (sel_i.cpu == CPU_SEL_W'(c)) rdata_o = mask_arr[c];
            end
            RK_MASKED: begin
                for (int c = 0; c < NUM_CPU; c++)
                    if (sel_i.cpu == CPU_SEL_W'(c)) rdata_o = raw_i & mask_arr[c];
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_W-1:0]     dev_irq_i,
    input  logic [REG_IDX_W-1:0] reg_idx_i,
    input  logic                 reg_wr_i,
    input  logic [SRC_W-1:0]     reg_wdata_i,
    output logic [SRC_W-1:0]     reg_rdata_o,
    output logic [NUM_CPU-1:0]   err_irq_o,
    output logic [NUM_CPU-1:0]   dev_irq_o
);
    localparam int MASK_BITS = NUM_CPU * SRC_W;

    reg_sel_t               sel;
    src_vec_t               raw_q;
    logic [MASK_BITS-1:0]   mask_flat;

    assign sel = decode_index(reg_idx_i);

    irq_raw_sampler u_raw (
        .clk   (clk),
        .rst   (rst),
        .dev_i (dev_irq_i),
        .raw_o (raw_q)
    );

    irq_mask_bank #(.NUM_CPU(NUM_CPU)) u_masks (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .sel_i   (sel),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_flat)
    );

    irq_cpu_lines #(.NUM_CPU(NUM_CPU)) u_lines (
        .clk    (clk),
        .rst    (rst),
        .dev_i  (dev_irq_i),
        .mask_i (mask_flat),
        .err_o  (err_irq_o),
        .dev_o  (dev_irq_o)
    );

    irq_read_mux #(.NUM_CPU(NUM_CPU)) u_rd (
        .sel_i   (sel),
        .raw_i   (raw_q),
        .mask_i  (mask_flat),
        .rdata_o (reg_rdata_o)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [SRC_W-1:0]         dev_irq_i,
    input logic [REG_IDX_W-1:0]     reg_idx_i,
    input logic                     reg_wr_i,
    input logic [SRC_W-1:0]         reg_wdata_i,
    input logic [SRC_W-1:0]         reg_rdata_o,
    input logic [NUM_CPU-1:0]       err_irq_o,
    input logic [NUM_CPU-1:0]       dev_irq_o,
    input logic [SRC_W-1:0]         raw_q,
    input logic [NUM_CPU*SRC_W-1:0] mask_flat
);
    assert_raw_follow_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> raw_q == $past(dev_irq_i));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (err_irq_o == '0 && dev_irq_o == '0 && raw_q == '0 && mask_flat == '0));

    assert_idle_masks_R6: assert property (@(posedge clk) disable iff (rst)
        !reg_wr_i |=> $stable(mask_flat));

    assert_ro_write_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && (reg_idx_i == RAW_IDX || reg_idx_i[5] || reg_idx_i[3:1] != 3'b100))
        |=> $stable(mask_flat));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assert_err_line_R3: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> err_irq_o[c] ==
                err_any($past(dev_irq_i) & $past(mask_flat[c*SRC_W +: SRC_W])));

        assert_dev_line_R4: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> dev_irq_o[c] ==
                dev_any($past(dev_irq_i) & $past(mask_flat[c*SRC_W +: SRC_W])));

        assert_mask_load_R5: assert property (@(posedge clk) disable iff (rst)
            (reg_wr_i && reg_idx_i == mask_index(2'(c)))
            |=> mask_flat[c*SRC_W +: SRC_W] == $past(reg_wdata_i));

        assert_masked_read_R2: assert property (@(posedge clk) disable iff (rst)
            (reg_idx_i == masked_index(2'(c)))
            |-> reg_rdata_o == (raw_q & mask_flat[c*SRC_W +: SRC_W]));
    end
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .dev_irq_i   (dev_irq_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .err_irq_o   (err_irq_o),
    .dev_irq_o   (dev_irq_o),
    .raw_q       (raw_q),
    .mask_flat   (mask_flat)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] dev_irq = '0;
    logic [5:0]  reg_idx = '0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [NCPU-1:0] err_irq;
    logic [NCPU-1:0] dev_line;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] tb_mask [NCPU];

    always #4 clk = ~clk;

    irq_router #(.NUM_CPU(NCPU)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .dev_irq_i   (dev_irq),
        .reg_idx_i   (reg_idx),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .err_irq_o   (err_irq),
        .dev_irq_o   (dev_line)
    );

    function automatic logic [5:0] mask_idx(input int c);
        return 6'(((c / 2) * 16) + 8 + (c % 2));
    endfunction

    function automatic logic [5:0] masked_idx(input int c);
        return 6'(((c / 2) * 16) + 10 + (c % 2));
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] idx, output logic [63:0] val);
        reg_idx = idx;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr(input logic [5:0] idx, input logic [63:0] val);
        @(negedge clk);
        reg_idx   = idx;
        reg_wdata = val;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic set_mask(input int c, input logic [63:0] val);
        wr(mask_idx(c), val);
        tb_mask[c] = val;
    endtask

    // The input must have been stable across the previous edge.
    task automatic check_state(input string ctx);
        logic [63:0] v;
        for (int c = 0; c < NCPU; c++) begin
            logic [63:0] m;
            m = dev_irq & tb_mask[c];
            check({ctx, " R3 err line"}, 64'(err_irq[c]), 64'(|m[63:58]));
            check({ctx, " R4 dev line"}, 64'(dev_line[c]), 64'(|m[55:0]));
            rd(masked_idx(c), v);
            check({ctx, " R2 masked read"}, v, m);
        end
        rd(6'h1C, v);
        check({ctx, " R1 raw read"}, v, dev_irq);
    endtask

    task automatic apply(input logic [63:0] pat, input string ctx);
        @(negedge clk);
        dev_irq = pat;
        @(negedge clk);
        check_state(ctx);
    endtask

    initial begin
        logic [63:0] v;
        for (int c = 0; c < NCPU; c++) tb_mask[c] = '0;

        // R7: reset holds everything at zero even with all inputs high.
        dev_irq = '1;
        repeat (3) @(negedge clk);
        check("R7 err lines in reset", 64'(err_irq), 64'd0);
        check("R7 dev lines in reset", 64'(dev_line), 64'd0);
        rd(6'h1C, v);
        check("R7 raw in reset", v, 64'd0);
        for (int c = 0; c < NCPU; c++) begin
            rd(mask_idx(c), v);
            check("R7 mask in reset", v, 64'd0);
        end
        dev_irq = '0;
        rst = 1'b0;
        @(negedge clk);

        // R5: load distinct masks and read them back.
        set_mask(0, '1);
        set_mask(1, 64'hFC00_0000_0000_0000);
        set_mask(2, 64'h0300_0000_0000_0000);
        set_mask(3, 64'h5555_5555_5555_5555);
        for (int c = 0; c < NCPU; c++) begin
            rd(mask_idx(c), v);
            check("R5 mask readback", v, tb_mask[c]);
        end

        // R3 R4 R1 R2: walking single source over every position.
        for (int b = 0; b < 64; b++) apply(64'd1 << b, "walk");

        // Dense patterns.
        apply('1, "all ones");
        apply(64'h00FF_FFFF_FFFF_FFFF, "device half");
        apply(64'h0300_0000_0000_0000, "dead bits");
        apply(64'hA000_0000_0000_0002, "mixed");
        apply(64'h8000_0000_0000_0000, "top bit");

        // R8: input change reaches the lines one edge later.
        apply('0, "idle");
        @(negedge clk);
        dev_irq = 64'd1 << 3;
        #1;
        check("R8 line before edge", 64'(dev_line[0]), 64'd0);
        @(negedge clk);
        check("R8 line after edge", 64'(dev_line[0]), 64'd1);

        // R8 R2: mask write reaches the lines one edge after the write edge.
        wr(mask_idx(0), 64'd0);
        tb_mask[0] = 64'd0;
        check("R8 line holds after mask write", 64'(dev_line[0]), 64'd1);
        rd(masked_idx(0), v);
        check("R2 masked read immediate", v, 64'd0);
        @(negedge clk);
        check("R8 line drops next edge", 64'(dev_line[0]), 64'd0);
        set_mask(0, '1);
        @(negedge clk);
        check_state("remask");

        // R6: writes to read-only and unmapped indices change nothing.
        wr(6'h0A, 64'h0);
        wr(6'h1B, 64'h0);
        wr(6'h1C, 64'h0);
        wr(6'h28, 64'h0);
        wr(6'h00, 64'h0);
        for (int c = 0; c < NCPU; c++) begin
            rd(mask_idx(c), v);
            check("R6 mask unchanged", v, tb_mask[c]);
        end
        apply(64'hFFFF_0000_0000_FFFF, "R6 after ignored writes");

        // R9: unmapped indices read zero.
        rd(6'h00, v);  check("R9 read 0x00", v, 64'd0);
        rd(6'h28, v);  check("R9 read 0x28", v, 64'd0);
        rd(6'h3F, v);  check("R9 read 0x3F", v, 64'd0);
        rd(6'h0C, v);  check("R9 read 0x0C", v, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule